// File: doc/BRIEF.md
# Video vertical counter generator

This block produces the 8-bit vertical position value that a processor reads back from a video display controller. It keeps an internal scanline number that advances on every line strobe. From that number it forms the externally visible counter. The visible counter is not the raw line number. On the line where the vertical interrupt is raised it is forced to a fixed code. After that line it jumps backwards once the line number reaches a region-dependent wrap point. In the double-resolution interlace mode its bits are rearranged.

The surrounding video timing logic pulses `line_strobe` once per scanline boundary. It may pulse `frame_sync` to restart the frame. It also holds the region and mode selects steady during a line. The counter, the line number and a one-cycle frame-start pulse are all registered. They change only on the clock edge that takes a strobe or a sync, so a reader sees one stable value for the whole line.

Top module: `vcount_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe, `line_num` is 0, `vcount` is 0x00 and `frame_start` is 0.
- R2: On an active line (line number below the active line count) with `ilace_mode` not equal to 2'b11, `vcount` equals the low 8 bits of the line number.
- R3: On an active line with `ilace_mode` equal to 2'b11 (double-resolution interlace), `vcount` is formed from the line number doubled, with bit 8 of the doubled value copied into bit 0, keeping the low 8 bits. That is, `vcount` = {line[6:0], line[7]}.
- R4: On the line whose number equals the active line count (the vertical interrupt line), `vcount` is 0xE0, or 0xC1 when `ilace_mode` is 2'b11.
- R5: The active line count is 240 when `pal_mode` is 1 and `tall_mode` is 1. In every other combination it is 224, so `tall_mode` has no effect when `pal_mode` is 0.
- R6: With `pal_mode` 0, on a line after the interrupt line, the counter base is the line number minus 6 once the line number is 0xEB (235) or more, and the line number itself before that.
- R7: With `pal_mode` 1, on a line after the interrupt line, the counter base is the line number minus 56 once the line number is 0x103 (259) or more, and the line number itself before that.
- R8: On a line after the interrupt line, `vcount` is the low 8 bits of the counter base from R6/R7 when `ilace_mode` is not 2'b11. When `ilace_mode` is 2'b11 it is the base doubled with bit 0 set to 1, keeping the low 8 bits.
- R9: A frame has 262 lines with `pal_mode` 0 and 313 with `pal_mode` 1. A strobe on the last line, or on any higher line, returns `line_num` to 0. Any other strobe adds 1.
- R10: `frame_start` is high for exactly the one clock cycle after the edge at which the line number is returned to 0, whether by wrap or by `frame_sync`. At all other times it is low.
- R11: `frame_sync` has priority over `line_strobe`. At the next edge it sets `line_num` to 0 and `vcount` to 0x00.
- R12: In cycles with neither `line_strobe` nor `frame_sync`, `vcount` and `line_num` hold their values even when `pal_mode`, `tall_mode` or `ilace_mode` change.
- R13: The `ilace_mode` values 2'b00, 2'b01 and 2'b10 all give the non-interlaced mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse at each scanline boundary |
| frame_sync | input | 1 | One-cycle pulse that restarts the frame at line 0 |
| pal_mode | input | 1 | 1 selects the 313-line region, 0 the 262-line region |
| tall_mode | input | 1 | 240-line active area request (effective in the 313-line region only) |
| ilace_mode | input | 2 | Interlace field; 2'b11 selects double-resolution interlace |
| vcount | output | 8 | Registered visible vertical counter |
| line_num | output | 9 | Registered internal scanline number |
| frame_start | output | 1 | One-cycle pulse after the line number returns to 0 |

## Verification
On every cycle, the assertions check the line-number stepping and wrap against the region total. They also check that both outputs hold between strobes, that a sync clears them, that `frame_start` only appears with line 0, and that the interrupt-line code follows the interlace field. Only the bench's scenarios show the full value mapping. That covers the active-line rotation in interlace mode, the backward jump at each region's wrap point, and the odd-valued codes after the interrupt line. It also covers the 224/240 choice across region and tall-mode combinations, and that the two non-matching interlace codes act as normal mode. Each of these needs a whole frame, or a large part of one, compared with an independent model.

// File: rtl/vcg_pkg.sv
package vcg_pkg;

  // Width of the internal scanline number (enough for 313 lines).
  localparam int LINE_W = 9;
  // Width of the visible counter.
  localparam int CNT_W  = 8;
  // Interlace field code that selects double-resolution interlace.
  localparam logic [1:0] ILACE_DOUBLE = 2'b11;

  // Frame geometry for the currently selected region and height.
  typedef struct packed {
    logic [LINE_W-1:0] act;    // number of active lines = interrupt line index
    logic [LINE_W-1:0] last;   // index of last line in the frame
    logic [LINE_W-1:0] wrap;   // first line where the backward jump applies
    logic [LINE_W-1:0] sub;    // amount subtracted from the line at/after wrap
  } geom_t;

  // Which part of the frame a line belongs to.
  typedef enum logic [1:0] {
    SEG_ACTIVE = 2'd0,
    SEG_VINT   = 2'd1,
    SEG_BLANK  = 2'd2
  } seg_e;

endpackage

// File: rtl/vcg_geom.sv
module vcg_geom
  import vcg_pkg::*;
#(
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 313,
  parameter int ACT_SHORT  = 224,
  parameter int ACT_TALL   = 240,
  parameter int NTSC_WRAP  = 235,
  parameter int PAL_WRAP   = 259,
  parameter int NTSC_SUB   = 6,
  parameter int PAL_SUB    = 56
) (
  input  logic  pal_mode,
  input  logic  tall_mode,
  output geom_t geom
);

  localparam logic [LINE_W-1:0] NTSC_LAST_C = LINE_W'(NTSC_LINES - 1);
  localparam logic [LINE_W-1:0] PAL_LAST_C  = LINE_W'(PAL_LINES - 1);
  localparam logic [LINE_W-1:0] SHORT_C     = LINE_W'(ACT_SHORT);
  localparam logic [LINE_W-1:0] TALL_C      = LINE_W'(ACT_TALL);

  logic tall_eff;

  // The tall active area exists only in the longer region.
  assign tall_eff = pal_mode & tall_mode;

  always_comb begin
    geom.act  = tall_eff ? TALL_C : SHORT_C;
    geom.last = pal_mode ? PAL_LAST_C : NTSC_LAST_C;
    geom.wrap = pal_mode ? LINE_W'(PAL_WRAP) : LINE_W'(NTSC_WRAP);
    geom.sub  = pal_mode ? LINE_W'(PAL_SUB)  : LINE_W'(NTSC_SUB);
  end

endmodule

// File: rtl/vcg_linectr.sv
module vcg_linectr
  import vcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic              frame_sync,
  input  logic [LINE_W-1:0] last_line,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nx,
  output logic              load,
  output logic              start_q
);

  logic at_end;
  logic to_zero;

  // ">=" rather than "==" so a region switch mid-frame cannot strand the
  // counter above the new last line.
  assign at_end  = (line_q >= last_line);
  assign to_zero = frame_sync | (line_strobe & at_end);
  assign load    = frame_sync | line_strobe;

  always_comb begin
    if (to_zero)
      line_nx = '0;
    else if (line_strobe)
      line_nx = line_q + LINE_W'(1);
    else
      line_nx = line_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      start_q <= 1'b0;
    end else begin
      line_q  <= line_nx;
      start_q <= to_zero;
    end
  end

endmodule

// File: rtl/vcg_map.sv
module vcg_map
  import vcg_pkg::*;
#(
  parameter logic [CNT_W-1:0] VINT_CODE       = 8'hE0,
  parameter logic [CNT_W-1:0] VINT_CODE_DOUBLE = 8'hC1
) (
  input  logic              [LINE_W-1:0] line,
  input  geom_t                          geom,
  input  logic              [1:0]        ilace_mode,
  output logic              [CNT_W-1:0]  vc
);

  logic                double;
  seg_e                seg;
  logic [LINE_W-1:0]   base;
  logic [CNT_W-1:0]    act_plain;
  logic [CNT_W-1:0]    act_rot;
  logic [CNT_W-1:0]    blank_plain;
  logic [CNT_W-1:0]    blank_dbl;

  assign double = (ilace_mode == ILACE_DOUBLE);

  always_comb begin
    if (line < geom.act)
      seg = SEG_ACTIVE;
    else if (line == geom.act)
      seg = SEG_VINT;
    else
      seg = SEG_BLANK;
  end

  // Backward jump after the region's wrap point.
  assign base = (line >= geom.wrap) ? (line - geom.sub) : line;

  assign act_plain   = line[CNT_W-1:0];
  assign blank_plain = base[CNT_W-1:0];

  // Doubled line with the overflow bit folded into bit 0: a left rotate of
  // the low byte. Doubled base with bit 0 set: a shift with fill of 1.
  assign act_rot[0]   = line[CNT_W-1];
  assign blank_dbl[0] = 1'b1;
  for (genvar i = 1; i < CNT_W; i++) begin : g_dbl
    assign act_rot[i]   = line[i-1];
    assign blank_dbl[i] = base[i-1];
  end

  always_comb begin
    unique case (seg)
      SEG_ACTIVE: vc = double ? act_rot : act_plain;
      SEG_VINT:   vc = double ? VINT_CODE_DOUBLE : VINT_CODE;
      default:    vc = double ? blank_dbl : blank_plain;
    endcase
  end

endmodule

// File: rtl/vcount_gen.sv
module vcount_gen
  import vcg_pkg::*;
#(
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 313,
  parameter int ACT_SHORT  = 224,
  parameter int ACT_TALL   = 240,
  parameter int NTSC_WRAP  = 235,
  parameter int PAL_WRAP   = 259,
  parameter int NTSC_SUB   = 6,
  parameter int PAL_SUB    = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_strobe,
  input  logic             frame_sync,
  input  logic             pal_mode,
  input  logic             tall_mode,
  input  logic [1:0]       ilace_mode,
  output logic [CNT_W-1:0] vcount,
  output logic [LINE_W-1:0] line_num,
  output logic             frame_start
);

  geom_t              geom;
  logic [LINE_W-1:0]  line_q;
  logic [LINE_W-1:0]  line_nx;
  logic               load;
  logic               start_q;
  logic [CNT_W-1:0]   vc_nx;
  logic [CNT_W-1:0]   vcount_q;

  vcg_geom #(
    .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .ACT_SHORT(ACT_SHORT),   .ACT_TALL(ACT_TALL),
    .NTSC_WRAP(NTSC_WRAP),   .PAL_WRAP(PAL_WRAP),
    .NTSC_SUB(NTSC_SUB),     .PAL_SUB(PAL_SUB)
  ) u_geom (
    .pal_mode  (pal_mode),
    .tall_mode (tall_mode),
    .geom      (geom)
  );

  vcg_linectr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_strobe (line_strobe),
    .frame_sync  (frame_sync),
    .last_line   (geom.last),
    .line_q      (line_q),
    .line_nx     (line_nx),
    .load        (load),
    .start_q     (start_q)
  );

  // Map the line being entered so counter and line number move together.
  vcg_map u_map (
    .line       (line_nx),
    .geom       (geom),
    .ilace_mode (ilace_mode),
    .vc         (vc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      vcount_q <= '0;
    else if (load)
      vcount_q <= vc_nx;
  end

  assign vcount      = vcount_q;
  assign line_num    = line_q;
  assign frame_start = start_q;

endmodule

// File: rtl/vcount_gen_chk.sv
module vcount_gen_chk
  import vcg_pkg::*;
#(
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 313,
  parameter int ACT_SHORT  = 224,
  parameter int ACT_TALL   = 240
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_strobe,
  input logic              frame_sync,
  input logic              pal_mode,
  input logic              tall_mode,
  input logic [1:0]        ilace_mode,
  input logic [CNT_W-1:0]  vcount,
  input logic [LINE_W-1:0] line_num,
  input logic              frame_start
);

  logic [LINE_W-1:0] last_c;
  logic [LINE_W-1:0] act_c;

  assign last_c = pal_mode ? LINE_W'(PAL_LINES - 1) : LINE_W'(NTSC_LINES - 1);
  assign act_c  = (pal_mode && tall_mode) ? LINE_W'(ACT_TALL) : LINE_W'(ACT_SHORT);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_strobe && !frame_sync) |=> ($stable(vcount) && $stable(line_num)));

  p_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (line_num == '0 && vcount == '0));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !frame_sync && line_num < last_c)
      |=> (line_num == $past(line_num) + LINE_W'(1)));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !frame_sync && line_num >= last_c) |=> (line_num == '0));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_num == '0));

  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_num < LINE_W'(PAL_LINES));

  p_vint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !frame_sync && line_num == act_c - LINE_W'(1))
      |=> (vcount == (($past(ilace_mode) == ILACE_DOUBLE) ? 8'hC1 : 8'hE0)));

endmodule

bind vcount_gen vcount_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_strobe (line_strobe),
  .frame_sync  (frame_sync),
  .pal_mode    (pal_mode),
  .tall_mode   (tall_mode),
  .ilace_mode  (ilace_mode),
  .vcount      (vcount),
  .line_num    (line_num),
  .frame_start (frame_start)
);

// File: tb/vcount_gen_test.sv
module vcount_gen_test;

  typedef struct {
    int    ln;
    int    vc;
    bit    fs;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_strobe = 1'b0;
  logic       frame_sync = 1'b0;
  logic       pal_mode = 1'b0;
  logic       tall_mode = 1'b0;
  logic [1:0] ilace_mode = 2'b00;
  logic [7:0] vcount;
  logic [8:0] line_num;
  logic       frame_start;

  int    total = 0;
  int    bad = 0;
  int    m_line = 0;
  item_t sb[$];

  always #4 clk = ~clk;

  vcount_gen uut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .frame_sync(frame_sync),
    .pal_mode(pal_mode), .tall_mode(tall_mode), .ilace_mode(ilace_mode),
    .vcount(vcount), .line_num(line_num), .frame_start(frame_start)
  );

  // Independent model of the visible counter for a given line.
  function automatic int exp_vc(int ln, bit pal, bit tall, bit [1:0] il);
    int act, adj, v;
    bit dbl;
    act = (pal && tall) ? 240 : 224;
    dbl = (il == 2'b11);
    if (ln < act) begin
      v = ln * 2;
      v = dbl ? ((v | (v >> 8)) & 255) : (ln & 255);
    end else if (ln == act) begin
      v = dbl ? 'hC1 : 'hE0;
    end else begin
      adj = ln;
      if (pal && ln >= 259) adj = ln - 56;
      if (!pal && ln >= 235) adj = ln - 6;
      v = dbl ? (((adj * 2) | 1) & 255) : (adj & 255);
    end
    return v;
  endfunction

  function automatic string tag_of(int ln, bit pal, bit tall, bit [1:0] il);
    int act;
    act = (pal && tall) ? 240 : 224;
    if (ln == 0) return "R9";
    if (ln == act) return "R4";
    if (ln < act) return (il == 2'b11) ? "R3" : "R2";
    if (il == 2'b11) return "R8";
    return pal ? "R7" : "R6";
  endfunction

  task automatic check(string req, int a_ln, int e_ln, int a_vc, int e_vc, bit a_fs, bit e_fs);
    total++;
    if (a_ln != e_ln || a_vc != e_vc || a_fs != e_fs) begin
      bad++;
      $display("FAIL %s line=%0d exp %0d vcount=%h exp %h frame_start=%b exp %b",
               req, a_ln, e_ln, a_vc, e_vc, a_fs, e_fs);
    end
  endtask

  // Driver: one line strobe, expectation pushed first.
  task automatic step(int gap, string tag_ovr);
    item_t it;
    int    last, nl;
    last = pal_mode ? 312 : 261;
    nl = (m_line >= last) ? 0 : m_line + 1;
    it.ln  = nl;
    it.vc  = exp_vc(nl, pal_mode, tall_mode, ilace_mode);
    it.fs  = (nl == 0);
    it.tag = (tag_ovr != "") ? tag_ovr : tag_of(nl, pal_mode, tall_mode, ilace_mode);
    sb.push_back(it);
    m_line = nl;
    line_strobe = 1'b1;
    @(negedge clk);
    line_strobe = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sync_pulse(bit with_strobe);
    item_t it;
    it.ln = 0; it.vc = 0; it.fs = 1'b1; it.tag = "R11";
    sb.push_back(it);
    m_line = 0;
    frame_sync = 1'b1;
    line_strobe = with_strobe;
    @(negedge clk);
    frame_sync = 1'b0;
    line_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_lines(int n, int gap, string tag_ovr);
    for (int i = 0; i < n; i++) step(gap, tag_ovr);
  endtask

  // Monitor: compares after each edge that took a strobe or sync.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && (line_strobe || frame_sync)) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard empty line=%0d vcount=%h", line_num, vcount);
        end else begin
          item_t e;
          e = sb.pop_front();
          check(e.tag, line_num, e.ln, vcount, e.vc, frame_start, e.fs);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hold_vc, hold_ln;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", line_num, 0, vcount, 0, frame_start, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", line_num, 0, vcount, 0, frame_start, 1'b0);

    // NTSC, plain, back-to-back strobes, full frame plus wrap (R2 R4 R6 R9 R10)
    run_lines(262, 0, "");
    // frame_start gone one cycle after the wrap pulse (R10)
    @(negedge clk);
    check("R10", line_num, 0, vcount, 0, frame_start, 1'b0);

    // NTSC with tall_mode requested: still 224 active lines (R5)
    tall_mode = 1'b1;
    run_lines(230, 1, "");
    check("R5", line_num, 230, vcount, 230 - 0, frame_start, 1'b0);
    sync_pulse(1'b1);

    // PAL tall frame: interrupt at 240, wrap at 259 less 56 (R5 R7)
    pal_mode = 1'b1;
    run_lines(313, 0, "");

    // PAL short frame, gapped strobes (R5 R7)
    tall_mode = 1'b0;
    run_lines(313, 2, "");

    // Double interlace, NTSC and PAL tall (R3 R8)
    ilace_mode = 2'b11;
    pal_mode = 1'b0;
    run_lines(262, 0, "");
    pal_mode = 1'b1;
    tall_mode = 1'b1;
    run_lines(313, 0, "");

    // Hold check: change every mode with no strobe (R12)
    run_lines(100, 0, "");
    @(negedge clk);
    hold_vc = vcount; hold_ln = line_num;
    ilace_mode = 2'b00; pal_mode = 1'b0; tall_mode = 1'b0;
    repeat (5) @(negedge clk);
    check("R12", line_num, hold_ln, vcount, hold_vc, frame_start, 1'b0);
    ilace_mode = 2'b11; pal_mode = 1'b1; tall_mode = 1'b1;
    repeat (5) @(negedge clk);
    check("R12", line_num, hold_ln, vcount, hold_vc, frame_start, 1'b0);

    // Sync restart mid-frame (R11), then other interlace codes (R13)
    sync_pulse(1'b0);
    pal_mode = 1'b0; tall_mode = 1'b0;
    ilace_mode = 2'b01;
    run_lines(262, 0, "R13");
    ilace_mode = 2'b10;
    run_lines(262, 0, "R13");

    repeat (4) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R9 scoreboard left %0d items, expected 0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule